// File: doc/BRIEF.md
# NAND Bus Cycle Decoder

This block is the device-side front end of a parallel NAND flash interface. It samples the chip select, the two latch selects, the write and read strobes, the write-protect line and the I/O bus, all in the system clock domain. It sorts each bus phase into one of a small set of kinds and, for every command byte, address byte or data word captured on a write-strobe rising edge, it emits a one-clock strobe that carries the captured value.

Every control line first passes through a two-flop synchronizer. The chip select and the two strobes then pass through a minimum-stable-sample filter, so that short spikes never count as bus activity. Write protect is read live at the moment of each capture; it is never held in a register clocked by the write strobe. The block numbers the address bytes that follow a command, drops any byte past the configured count, drives a read output-enable during the low phase of a read cycle, and gives one advance pulse per completed read cycle.

Top module: `nand_cycle_decoder`

## Requirements
- R1: With chip select low, command latch high, address latch low and read strobe high, a write-strobe rising edge gives one `cmd_vld_o` pulse with `cmd_o` = I/O[7:0], and the address byte count goes back to zero.
- R2: With chip select low, address latch high, command latch low and read strobe high, a write-strobe rising edge gives one `addr_vld_o` pulse with `addr_o` = I/O[7:0] and `addr_idx_o` = its position after the last command (0 for the first byte).
- R3: Address bytes at positions `ADDR_CYCLES` and above (the fifth and later by default) are dropped with no strobe and no error pulse.
- R4: With both latch selects low and read strobe high, a write-strobe rising edge gives one `data_vld_o` pulse with `data_o` = the full I/O word only if write protect is high; with write protect low nothing is emitted.
- R5: `cmd_prot_o` is 1 on a command pulse exactly when write protect is low at the rising edge of the write strobe; its level earlier in the low phase has no effect.
- R6: A low pulse on the write strobe, the read strobe or the chip select that lasts fewer than `FILT_LEN` clock samples causes no strobe and no advance pulse.
- R7: While chip select is low, write strobe high, both latch selects low and read strobe low, `oe_o` is 1 and `cycle_o` is 5; each completed read strobe cycle gives one `rd_adv_o` pulse.
- R8: While chip select is high, `oe_o` is 0, `cycle_o` is 0, and a write-strobe cycle gives no strobe at all.
- R9: A write-strobe rising edge with both latch selects high gives one `perr_o` pulse and no other strobe.
- R10: `cycle_o` encodes the settled bus state: 0 standby, 1 selected and idle, 2 command input, 3 address input, 4 data input, 5 data output, 6 data input held off by write protect; at most one of the five pulse outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Chip select, active low |
| cle_i | input | 1 | Command latch select |
| ale_i | input | 1 | Address latch select |
| we_n_i | input | 1 | Write strobe, active low, captures on rising edge |
| re_n_i | input | 1 | Read strobe, active low |
| wp_n_i | input | 1 | Write protect, active low |
| io_i | input | IO_W | I/O bus |
| cmd_vld_o | output | 1 | Command captured pulse |
| cmd_o | output | 8 | Captured command byte |
| cmd_prot_o | output | 1 | Write protect was low at that command |
| addr_vld_o | output | 1 | Address byte captured pulse |
| addr_o | output | 8 | Captured address byte |
| addr_idx_o | output | clog2(ADDR_CYCLES+1) | Position of that address byte |
| data_vld_o | output | 1 | Data word captured pulse |
| data_o | output | IO_W | Captured data word |
| rd_adv_o | output | 1 | One pulse per completed read cycle |
| oe_o | output | 1 | Output driver enable |
| perr_o | output | 1 | Both latch selects high at a capture |
| cycle_o | output | 3 | Current bus cycle kind |

## Verification
The bench goes after a fifth address byte, which a design without the count limit would pass on with index 4, and a write strobe spike of a single clock, which an unfiltered design would take as a full command. It drops write protect during the strobe low phase and raises it again before the rising edge, so a design that latched the level on the falling edge would flag the command as protected. It also drives write strobes with both latch selects high and with chip select high, where a loose decoder would emit a command or address strobe.

// File: rtl/nand_dec_pkg.sv
package nand_dec_pkg;

    typedef enum logic [2:0] {
        K_STANDBY = 3'd0,
        K_IDLE    = 3'd1,
        K_CMD     = 3'd2,
        K_ADDR    = 3'd3,
        K_DIN     = 3'd4,
        K_DOUT    = 3'd5,
        K_WPROT   = 3'd6
    } cycle_kind_e;

endpackage

// File: rtl/nand_sync.sv
module nand_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/nand_glitch_filter.sv
module nand_glitch_filter #(
    parameter int   LEN     = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic out_o
);
    localparam int CW = (LEN < 2) ? 1 : $clog2(LEN);

    logic          out_d, out_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        out_d = out_q;
        cnt_d = '0;
        if (in_i != out_q) begin
            if (cnt_q == CW'(LEN - 1)) begin
                out_d = in_i;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= RST_VAL;
            cnt_q <= '0;
        end else begin
            out_q <= out_d;
            cnt_q <= cnt_d;
        end
    end

    assign out_o = out_q;

    // R6: the filtered level only moves to a value the input already held
    p_filter_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q != $past(out_q)) |-> ($past(in_i) == out_q));
endmodule

// File: rtl/nand_cycle_decoder.sv
module nand_cycle_decoder
    import nand_dec_pkg::*;
#(
    parameter int IO_W        = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 2,
    parameter int ADDR_CYCLES = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               ce_n_i,
    input  logic                               cle_i,
    input  logic                               ale_i,
    input  logic                               we_n_i,
    input  logic                               re_n_i,
    input  logic                               wp_n_i,
    input  logic [IO_W-1:0]                    io_i,
    output logic                               cmd_vld_o,
    output logic [7:0]                         cmd_o,
    output logic                               cmd_prot_o,
    output logic                               addr_vld_o,
    output logic [7:0]                         addr_o,
    output logic [$clog2(ADDR_CYCLES+1)-1:0]   addr_idx_o,
    output logic                               data_vld_o,
    output logic [IO_W-1:0]                    data_o,
    output logic                               rd_adv_o,
    output logic                               oe_o,
    output logic                               perr_o,
    output logic [2:0]                         cycle_o
);
    localparam int ACW     = $clog2(ADDR_CYCLES + 1);
    localparam int NCTL    = 6;
    localparam int NFILT   = 3;
    // control vector layout: {ce_n, cle, ale, we_n, re_n, wp_n}
    localparam int FIDX [NFILT] = '{5, 2, 1};

    logic [NCTL-1:0] ctl_s;
    logic [IO_W-1:0] io_s;
    logic [NFILT-1:0] filt;

    nand_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(6'b100110)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({ce_n_i, cle_i, ale_i, we_n_i, re_n_i, wp_n_i}),
        .q_o(ctl_s)
    );

    nand_sync #(.W(IO_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_io_sync (
        .clk(clk), .rst_n(rst_n), .d_i(io_i), .q_o(io_s)
    );

    for (genvar g = 0; g < NFILT; g++) begin : g_filt
        nand_glitch_filter #(.LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
            .clk(clk), .rst_n(rst_n),
            .in_i(ctl_s[FIDX[g]]), .out_o(filt[g])
        );
    end

    logic ce_f, we_f, re_f;
    logic cle_s, ale_s, we_s, wp_s;
    assign ce_f  = filt[0];
    assign we_f  = filt[1];
    assign re_f  = filt[2];
    assign cle_s = ctl_s[4];
    assign ale_s = ctl_s[3];
    assign we_s  = ctl_s[2];
    assign wp_s  = ctl_s[0];

    typedef struct packed {
        logic            we_p;
        logic            re_p;
        logic            cle_h;
        logic            ale_h;
        logic [IO_W-1:0] io_h;
        logic [ACW-1:0]  acnt;
        logic            cmd_vld;
        logic [7:0]      cmd;
        logic            cmd_prot;
        logic            addr_vld;
        logic [7:0]      addr;
        logic [ACW-1:0]  aidx;
        logic            data_vld;
        logic [IO_W-1:0] data;
        logic            rd_adv;
        logic            oe;
        logic            perr;
        cycle_kind_e     kind;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic we_rise, re_rise;

    always_comb begin
        st_d          = st_q;
        st_d.cmd_vld  = 1'b0;
        st_d.addr_vld = 1'b0;
        st_d.data_vld = 1'b0;
        st_d.rd_adv   = 1'b0;
        st_d.perr     = 1'b0;
        st_d.we_p     = we_f;
        st_d.re_p     = re_f;

        // bus levels are held while the write strobe is low, so the rising
        // edge seen after filtering still uses the levels of that phase
        if (!we_s) begin
            st_d.cle_h = cle_s;
            st_d.ale_h = ale_s;
            st_d.io_h  = io_s;
        end

        we_rise = !st_q.we_p && we_f && !ce_f;
        re_rise = !st_q.re_p && re_f && !ce_f && we_f && !cle_s && !ale_s;

        if (we_rise && re_f) begin
            unique case ({st_q.cle_h, st_q.ale_h})
                2'b11: st_d.perr = 1'b1;
                2'b10: begin
                    st_d.cmd_vld  = 1'b1;
                    st_d.cmd      = st_q.io_h[7:0];
                    st_d.cmd_prot = !wp_s;
                    st_d.acnt     = '0;
                end
                2'b01: begin
                    if (st_q.acnt < ACW'(ADDR_CYCLES)) begin
                        st_d.addr_vld = 1'b1;
                        st_d.addr     = st_q.io_h[7:0];
                        st_d.aidx     = st_q.acnt;
                        st_d.acnt     = st_q.acnt + 1'b1;
                    end
                end
                default: begin
                    if (wp_s) begin
                        st_d.data_vld = 1'b1;
                        st_d.data     = st_q.io_h;
                    end
                end
            endcase
        end

        if (re_rise) st_d.rd_adv = 1'b1;

        st_d.oe = !ce_f && !re_f && we_f && !cle_s && !ale_s;

        if (ce_f)                                 st_d.kind = K_STANDBY;
        else if (!re_f && we_f && !cle_s && !ale_s) st_d.kind = K_DOUT;
        else if (!we_f && cle_s && !ale_s)        st_d.kind = K_CMD;
        else if (!we_f && ale_s && !cle_s)        st_d.kind = K_ADDR;
        else if (!we_f && !ale_s && !cle_s)       st_d.kind = wp_s ? K_DIN : K_WPROT;
        else                                      st_d.kind = K_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.we_p <= 1'b1;
            st_q.re_p <= 1'b1;
            st_q.kind <= K_STANDBY;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_vld_o  = st_q.cmd_vld;
    assign cmd_o      = st_q.cmd;
    assign cmd_prot_o = st_q.cmd_prot;
    assign addr_vld_o = st_q.addr_vld;
    assign addr_o     = st_q.addr;
    assign addr_idx_o = st_q.aidx;
    assign data_vld_o = st_q.data_vld;
    assign data_o     = st_q.data;
    assign rd_adv_o   = st_q.rd_adv;
    assign oe_o       = st_q.oe;
    assign perr_o     = st_q.perr;
    assign cycle_o    = st_q.kind;

    p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.cmd_vld, st_q.addr_vld, st_q.data_vld, st_q.rd_adv, st_q.perr}));

    p_cmd_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cmd_vld |=> !st_q.cmd_vld);

    p_addr_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.addr_vld |-> (st_q.aidx < ACW'(ADDR_CYCLES)));

    p_data_wp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.data_vld |-> $past(wp_s));

    p_standby_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.kind == K_STANDBY) |-> (!st_q.oe && !st_q.cmd_vld && !st_q.addr_vld && !st_q.data_vld));

    p_oe_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.oe |-> (st_q.kind == K_DOUT));
endmodule

// File: tb/test_nand_cycle_decoder.sv
module test_nand_cycle_decoder;
    localparam int IO_W = 8;
    localparam int NADDR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [IO_W-1:0] io = '0;

    logic       cmd_vld, cmd_prot, addr_vld, data_vld, rd_adv, oe, perr;
    logic [7:0] cmd, addr;
    logic [2:0] aidx, cyc;
    logic [IO_W-1:0] dat;

    always #10 clk = ~clk;

    nand_cycle_decoder #(.IO_W(IO_W), .ADDR_CYCLES(NADDR)) i_nand_cycle_decoder (
        .clk(clk), .rst_n(rst_n),
        .ce_n_i(ce_n), .cle_i(cle), .ale_i(ale), .we_n_i(we_n), .re_n_i(re_n), .wp_n_i(wp_n),
        .io_i(io),
        .cmd_vld_o(cmd_vld), .cmd_o(cmd), .cmd_prot_o(cmd_prot),
        .addr_vld_o(addr_vld), .addr_o(addr), .addr_idx_o(aidx),
        .data_vld_o(data_vld), .data_o(dat),
        .rd_adv_o(rd_adv), .oe_o(oe), .perr_o(perr), .cycle_o(cyc)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int exp_cmd [$];
    int exp_addr [$];
    int exp_data [$];
    int exp_perr = 0;
    int exp_rd = 0;
    int model_acnt = 0;
    int ce_hi_cnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // reference model of one write-strobe capture, from the requirements
    task automatic model_capture(input bit c, input bit a, input bit wp, input logic [IO_W-1:0] v);
        if (ce_n) return;
        if (c && a) exp_perr++;
        else if (c) begin exp_cmd.push_back({!wp, v[7:0]}); model_acnt = 0; end
        else if (a) begin
            if (model_acnt < NADDR) exp_addr.push_back({model_acnt[2:0], v[7:0]});
            if (model_acnt < NADDR) model_acnt++;
        end
        else if (wp) exp_data.push_back(int'(v));
    endtask

    // per-clock comparison of every pulse against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_vld) begin
                if (exp_cmd.size() == 0) chk(0, "R1 unexpected cmd", int'(cmd), 0);
                else begin
                    automatic int e = exp_cmd.pop_front();
                    chk({cmd_prot, cmd} == e[8:0], "R1/R5 cmd", int'({cmd_prot, cmd}), e);
                end
            end
            if (addr_vld) begin
                if (exp_addr.size() == 0) chk(0, "R3 unexpected addr", int'({aidx, addr}), 0);
                else begin
                    automatic int e = exp_addr.pop_front();
                    chk({aidx, addr} == e[10:0], "R2 addr", int'({aidx, addr}), e);
                end
            end
            if (data_vld) begin
                if (exp_data.size() == 0) chk(0, "R4 unexpected data", int'(dat), 0);
                else begin
                    automatic int e = exp_data.pop_front();
                    chk(int'(dat) == e, "R4 data", int'(dat), e);
                end
            end
            if (perr) begin
                chk(exp_perr > 0, "R9 unexpected perr", 1, 0);
                if (exp_perr > 0) exp_perr--;
            end
            if (rd_adv) begin
                chk(exp_rd > 0, "R7/R6 unexpected rd_adv", 1, 0);
                if (exp_rd > 0) exp_rd--;
            end
            ce_hi_cnt = ce_n ? ce_hi_cnt + 1 : 0;
            if (ce_hi_cnt > 8)
                chk(!oe && cyc == 3'd0, "R8 standby", int'({oe, cyc}), 0);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one write cycle; wp_lo is the level during the low phase, wp_rise at the edge
    task automatic wr(input bit c, input bit a, input logic [IO_W-1:0] v,
                      input bit wp_lo, input bit wp_rise, input int expect_kind);
        cle = c; ale = a; io = v; wp_n = wp_lo; re_n = 1'b1;
        wait_n(2);
        we_n = 1'b0;
        wait_n(6);
        if (expect_kind >= 0) chk(cyc == expect_kind[2:0], "R10 cycle kind", int'(cyc), expect_kind);
        wp_n = wp_rise;
        wait_n(1);
        model_capture(c, a, wp_rise, v);
        we_n = 1'b1;
        wait_n(8);
        cle = 1'b0; ale = 1'b0; wp_n = 1'b1;
        wait_n(2);
    endtask

    task automatic rd_cycle;
        cle = 1'b0; ale = 1'b0; we_n = 1'b1;
        wait_n(2);
        re_n = 1'b0;
        wait_n(6);
        chk(oe == 1'b1, "R7 oe in read", int'(oe), 1);
        chk(cyc == 3'd5, "R7 cycle data out", int'(cyc), 5);
        exp_rd++;
        re_n = 1'b1;
        wait_n(8);
        chk(oe == 1'b0, "R7 oe after read", int'(oe), 0);
    endtask

    initial begin
        wait_n(3);
        chk(cyc == 3'd0 && !oe && !cmd_vld, "R8 reset state", int'({oe, cyc}), 0);
        rst_n = 1'b1;
        wait_n(10);
        chk(cyc == 3'd0, "R8 standby after reset", int'(cyc), 0);

        // write cycle with chip select high: nothing captured
        cle = 1'b1; io = 8'h60; wait_n(2); we_n = 1'b0; wait_n(5); we_n = 1'b1; wait_n(10);
        cle = 1'b0;

        ce_n = 1'b0;
        wait_n(8);
        chk(cyc == 3'd1, "R10 selected idle", int'(cyc), 1);

        // R1 command, then R2 four addresses, R3 fifth dropped
        wr(1, 0, 8'h80, 1, 1, 2);
        for (int i = 0; i < 5; i++) wr(0, 1, 8'h10 + i[7:0], 1, 1, 3);
        chk(exp_addr.size() == 0, "R3 fifth address dropped", exp_addr.size(), 0);
        // R4 data with WP high, then WP low (held off)
        wr(0, 0, 8'hA5, 1, 1, 4);
        wr(0, 0, 8'h3C, 1, 1, 4);
        wr(0, 0, 8'h5A, 0, 0, 6);
        // R1 a new command resets the address count
        wr(1, 0, 8'h00, 1, 1, 2);
        wr(0, 1, 8'hEE, 1, 1, 3);
        // R5 live write protect
        wr(1, 0, 8'h60, 1, 0, 2);
        wr(1, 0, 8'hD0, 0, 1, -1);
        // R9 both latch selects high
        wr(1, 1, 8'hFF, 1, 1, 1);

        // R6 one-sample write strobe spike with command latch high
        cle = 1'b1; io = 8'h70; wait_n(3);
        we_n = 1'b0; wait_n(1); we_n = 1'b1; wait_n(10);
        cle = 1'b0; wait_n(2);

        // R7 read cycles; R6 one-sample read spike
        rd_cycle();
        rd_cycle();
        re_n = 1'b0; wait_n(1); re_n = 1'b1; wait_n(10);
        chk(!oe, "R6 read spike oe", int'(oe), 0);

        // R6 chip select spike high during idle: no standby
        ce_n = 1'b1; wait_n(1); ce_n = 1'b0; wait_n(10);
        chk(cyc == 3'd1, "R6 chip select spike", int'(cyc), 1);

        ce_n = 1'b1;
        wait_n(15);
        chk(exp_cmd.size() == 0, "R1 all commands seen", exp_cmd.size(), 0);
        chk(exp_data.size() == 0, "R4 all data seen", exp_data.size(), 0);
        chk(exp_perr == 0, "R9 perr seen", exp_perr, 0);
        chk(exp_rd == 0, "R7 read advances seen", exp_rd, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule